// File: doc/BRIEF.md
# Solar Li-ion Charge Sequencer

This block is the digital sequencer of a switching Li-ion charger fed from a photovoltaic source. It steps a charge cycle through four states: idle, trickle (pre-charge), bulk (constant-current) and top-off (end-of-charge at the termination voltage). It does not measure anything itself. Analog comparators report where the battery voltage and the charge current stand, and separate detectors report faults. An enable input gates the whole cycle, and a one-minute tick drives two timers.

The sequencer tells the power stage which current limit is in force. It raises one-cycle pulses when either of its two timers expires, and it holds a flag once a cycle has finished normally. Two 3-bit codes set the timer lengths. The full-charge timer covers the bulk and top-off phases, and its disable code is 0. The top-off timer covers only the top-off phase, and its disable code is 7. Any fault, a low enable, or a timer expiry sends the machine back to idle, where both timers are cleared.

The hysteresis on the pre-charge level is built into the comparators. `vb_above_pre` means the battery is above 3.0 V, and `vb_below_pre_hys` means it is below 2.9 V. The restart comparator trips 100 mV below the termination voltage. The over-voltage detector trips at 102 % of the termination setting and reports on a fault bit. The top-off end comparator's reference, 25 mA or 92 mA, is chosen outside this block.

Top module: `solar_chg_seq`

## Requirements
- R1: While and after synchronous reset, `state` is 0 (idle), `lim_sel` is 0, and `fc_timeout`, `to_timeout` and `chg_done` are 0.
- R2: Idle is left for trickle (`state`=1) only when `chg_en` is 1, `fault_flags` is all zero and `vb_below_restart` is 1. Otherwise the machine stays in idle.
- R3: From trickle the machine moves to bulk (`state`=2) in the cycle after `vb_above_pre` is seen. From bulk it returns to trickle in the cycle after `vb_below_pre_hys` is seen.
- R4: From bulk the machine moves to top-off (`state`=3) in the cycle after `vb_at_term` and `i_below_eoc` are both 1.
- R5: In top-off, `vb_at_term` together with `i_below_topend` ends the cycle: the next state is idle and `chg_done` becomes 1. The flag holds until the machine next leaves idle.
- R6: The full-charge timer counts `min_tick` pulses while the machine is in bulk or top-off, and holds its count in trickle. For `fc_code`=N with N in 1..7, `fc_timeout` pulses when 200·N ticks have been counted, and the next state is idle. `fc_code`=0 disables the timer.
- R7: The top-off timer counts ticks while the machine is in top-off. For `to_code`=N with N in 0..6, `to_timeout` pulses after 20·N ticks and the next state is idle. Code 0 therefore pulses in the first top-off cycle. `to_code`=7 disables the timer.
- R8: If any bit of `fault_flags` is 1, or `chg_en` is 0, the next state is idle from any state. In that cycle neither timeout pulse is raised.
- R9: Both timers clear to zero while the machine is in idle, so each new cycle gets the full timer length.
- R10: `lim_sel` is 0 (no charging) in idle, 1 (pre-charge current) in trickle, 2 (full charge-current limit) in bulk and 3 (voltage regulation) in top-off.
- R11: Priority in one cycle runs as follows: fault or low enable, then full-charge expiry, then top-off expiry, then normal completion. A suppressed event raises no pulse and does not set `chg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chg_en | input | 1 | Charge enable |
| fault_flags | input | FLT_W | Fault detectors (over-voltage, temperature, others); any set bit is a fault |
| vb_above_pre | input | 1 | Battery above the pre-charge level (3.0 V) |
| vb_below_pre_hys | input | 1 | Battery below the pre-charge level minus hysteresis (2.9 V) |
| vb_at_term | input | 1 | Battery at termination voltage |
| vb_below_restart | input | 1 | Battery 100 mV or more below termination |
| i_below_eoc | input | 1 | Charge current below end-of-charge current |
| i_below_topend | input | 1 | Charge current below top-off end current |
| min_tick | input | 1 | One-cycle pulse per minute |
| fc_code | input | 3 | Full-charge timer code |
| to_code | input | 3 | Top-off timer code |
| state | output | 2 | Current state (0 idle, 1 trickle, 2 bulk, 3 top-off) |
| lim_sel | output | 2 | Active current-limit selector |
| fc_timeout | output | 1 | Full-charge timer expiry pulse |
| to_timeout | output | 1 | Top-off timer expiry pulse |
| chg_done | output | 1 | Charge cycle completed normally |

## Verification
State and `lim_sel` change one clock edge after the comparator condition is presented. The timeout pulses and the completion event are combinational on registered state, so they appear in the same cycle as the count or condition that causes them. The following edge then returns the machine to idle and, for completion, sets `chg_done`. The bench drives inputs just after the falling edge. It compares every output against a behavioural model at each falling edge, before the inputs change. It counts timer lengths in rising edges that carry a tick, so a timer of N ticks must pulse exactly at the N-th edge.

// File: rtl/chgseq_pkg.sv
package chgseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_BULK = 2'd2,
        ST_TOP  = 2'd3
    } chg_state_e;

    typedef enum logic [1:0] {
        LIM_OFF     = 2'd0,
        LIM_TRICKLE = 2'd1,
        LIM_FULL    = 2'd2,
        LIM_CV      = 2'd3
    } lim_sel_e;

    typedef struct packed {
        logic vb_above_pre;
        logic vb_below_pre_hys;
        logic vb_at_term;
        logic vb_below_restart;
        logic i_below_eoc;
        logic i_below_topend;
    } sense_t;

    localparam int TMR_CODE_W    = 3;
    localparam int FC_STEP_MIN   = 200;
    localparam int TOP_STEP_MIN  = 20;
    localparam int FC_DIS_CODE   = 0;
    localparam int TOP_DIS_CODE  = 7;

    function automatic lim_sel_e lim_for(input chg_state_e s);
        case (s)
            ST_PRE:  return LIM_TRICKLE;
            ST_BULK: return LIM_FULL;
            ST_TOP:  return LIM_CV;
            default: return LIM_OFF;
        endcase
    endfunction

    function automatic logic is_charging(input chg_state_e s);
        return (s == ST_BULK) || (s == ST_TOP);
    endfunction

endpackage

// File: rtl/chgseq_min_timer.sv
module chgseq_min_timer #(
    parameter int STEP     = 200,
    parameter int CODE_W   = 3,
    parameter int DIS_CODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              expired
);
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int CW       = $clog2(MAX_CODE * STEP + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_CODE * STEP);
    localparam logic [CW-1:0] STEP_W  = CW'(STEP);
    localparam logic [CODE_W-1:0] DIS_W = CODE_W'(DIS_CODE);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          enabled;

    always_comb begin
        limit   = CW'(code) * STEP_W;
        enabled = (code != DIS_W);
        expired = enabled && (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && tick && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_timer_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    assert_timer_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cnt));

endmodule

// File: rtl/chgseq_fsm.sv
module chgseq_fsm
    import chgseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  sense_t     sns,
    input  logic       fc_expired,
    input  logic       to_expired,
    output chg_state_e st,
    output logic       fc_pulse,
    output logic       to_pulse,
    output logic       done
);
    chg_state_e st_nxt;
    logic       done_evt;
    logic       start_evt;

    always_comb begin
        fc_pulse  = !kill && is_charging(st) && fc_expired;
        to_pulse  = !kill && !fc_pulse && (st == ST_TOP) && to_expired;
        done_evt  = !kill && !fc_pulse && !to_pulse && (st == ST_TOP)
                    && sns.vb_at_term && sns.i_below_topend;
        start_evt = !kill && (st == ST_IDLE) && sns.vb_below_restart;

        st_nxt = st;
        if (kill || fc_pulse || to_pulse || done_evt) begin
            st_nxt = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (start_evt) st_nxt = ST_PRE;
                ST_PRE:  if (sns.vb_above_pre) st_nxt = ST_BULK;
                ST_BULK: begin
                    if (sns.vb_below_pre_hys)
                        st_nxt = ST_PRE;
                    else if (sns.vb_at_term && sns.i_below_eoc)
                        st_nxt = ST_TOP;
                end
                default: st_nxt = ST_TOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            st <= st_nxt;
            if (done_evt)
                done <= 1'b1;
            else if (start_evt)
                done <= 1'b0;
        end
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && (kill || !sns.vb_below_restart)) |=> (st == ST_IDLE));

    assert_pre_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PRE && !kill && sns.vb_above_pre) |=> (st == ST_BULK));

    assert_kill_idle_R8: assert property (@(posedge clk) disable iff (rst)
        kill |=> (st == ST_IDLE));

    assert_kill_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        kill |-> (!fc_pulse && !to_pulse));

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (st == ST_IDLE));

    assert_pulse_prio_R11: assert property (@(posedge clk) disable iff (rst)
        fc_pulse |-> !to_pulse);

    assert_fc_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
        fc_pulse |=> (st == ST_IDLE));

endmodule

// File: rtl/solar_chg_seq.sv
module solar_chg_seq
    import chgseq_pkg::*;
#(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chg_en,
    input  logic [FLT_W-1:0] fault_flags,
    input  logic             vb_above_pre,
    input  logic             vb_below_pre_hys,
    input  logic             vb_at_term,
    input  logic             vb_below_restart,
    input  logic             i_below_eoc,
    input  logic             i_below_topend,
    input  logic             min_tick,
    input  logic [2:0]       fc_code,
    input  logic [2:0]       to_code,
    output logic [1:0]       state,
    output logic [1:0]       lim_sel,
    output logic             fc_timeout,
    output logic             to_timeout,
    output logic             chg_done
);
    chg_state_e st;
    sense_t     sns;
    logic       kill;
    logic       fc_exp;
    logic       to_exp;
    logic       in_idle;

    always_comb begin
        kill                 = !chg_en || (|fault_flags);
        sns.vb_above_pre     = vb_above_pre;
        sns.vb_below_pre_hys = vb_below_pre_hys;
        sns.vb_at_term       = vb_at_term;
        sns.vb_below_restart = vb_below_restart;
        sns.i_below_eoc      = i_below_eoc;
        sns.i_below_topend   = i_below_topend;
        in_idle              = (st == ST_IDLE);
        state                = st;
        lim_sel              = lim_for(st);
    end

    chgseq_min_timer #(
        .STEP     (FC_STEP_MIN),
        .CODE_W   (TMR_CODE_W),
        .DIS_CODE (FC_DIS_CODE)
    ) u_fc_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (in_idle),
        .run     (is_charging(st)),
        .tick    (min_tick),
        .code    (fc_code),
        .expired (fc_exp)
    );

    chgseq_min_timer #(
        .STEP     (TOP_STEP_MIN),
        .CODE_W   (TMR_CODE_W),
        .DIS_CODE (TOP_DIS_CODE)
    ) u_top_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (in_idle),
        .run     (st == ST_TOP),
        .tick    (min_tick),
        .code    (to_code),
        .expired (to_exp)
    );

    chgseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .kill       (kill),
        .sns        (sns),
        .fc_expired (fc_exp),
        .to_expired (to_exp),
        .st         (st),
        .fc_pulse   (fc_timeout),
        .to_pulse   (to_timeout),
        .done       (chg_done)
    );

    assert_fc_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (fc_code == 3'd0) |-> !fc_timeout);

    assert_top_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        (to_code == 3'd7) |-> !to_timeout);

    assert_top_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TOP && to_code == 3'd0 && fc_code == 3'd0 && !kill) |-> to_timeout);

    assert_lim_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0) |-> (lim_sel == 2'd0));

endmodule

// File: tb/solar_chg_seq_tb.sv
`timescale 1ns/1ps
module solar_chg_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chg_en = 1'b0;
    logic [3:0] fault_flags = '0;
    logic       vb_above_pre = 1'b0, vb_below_pre_hys = 1'b0, vb_at_term = 1'b0;
    logic       vb_below_restart = 1'b0, i_below_eoc = 1'b0, i_below_topend = 1'b0;
    logic       min_tick = 1'b0;
    logic [2:0] fc_code = 3'd0, to_code = 3'd7;
    logic [1:0] state, lim_sel;
    logic       fc_timeout, to_timeout, chg_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    solar_chg_seq #(.FLT_W(4)) u_dut (
        .clk(clk), .rst(rst), .chg_en(chg_en), .fault_flags(fault_flags),
        .vb_above_pre(vb_above_pre), .vb_below_pre_hys(vb_below_pre_hys),
        .vb_at_term(vb_at_term), .vb_below_restart(vb_below_restart),
        .i_below_eoc(i_below_eoc), .i_below_topend(i_below_topend),
        .min_tick(min_tick), .fc_code(fc_code), .to_code(to_code),
        .state(state), .lim_sel(lim_sel), .fc_timeout(fc_timeout),
        .to_timeout(to_timeout), .chg_done(chg_done)
    );

    // behavioural reference model
    int  m_st = 0, m_fc = 0, m_to = 0;
    bit  m_done = 0;
    bit  e_fc, e_to, e_fin;
    int  e_next;

    task automatic model_eval();
        bit kill;
        kill  = !chg_en || (fault_flags != 0);
        e_fc  = !kill && (m_st >= 2) && (fc_code != 0) && (m_fc >= fc_code * 200);
        e_to  = !kill && !e_fc && (m_st == 3) && (to_code != 7) && (m_to >= to_code * 20);
        e_fin = !kill && !e_fc && !e_to && (m_st == 3) && vb_at_term && i_below_topend;
        e_next = m_st;
        if (kill || e_fc || e_to || e_fin) e_next = 0;
        else if (m_st == 0 && vb_below_restart) e_next = 1;
        else if (m_st == 1 && vb_above_pre) e_next = 2;
        else if (m_st == 2 && vb_below_pre_hys) e_next = 1;
        else if (m_st == 2 && vb_at_term && i_below_eoc) e_next = 3;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_fc = 0; m_to = 0; m_done = 0;
        end else begin
            model_eval();
            if (e_fin) m_done = 1;
            else if (m_st == 0 && e_next == 1) m_done = 0;
            if (m_st == 0) m_fc = 0;
            else if (m_st >= 2 && min_tick && m_fc < 1400) m_fc++;
            if (m_st == 0) m_to = 0;
            else if (m_st == 3 && min_tick && m_to < 140) m_to++;
            m_st = e_next;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            model_eval();
            chk(state == 2'(m_st), cur_req, state, m_st);
            chk(lim_sel == 2'(m_st), "R10", lim_sel, m_st);
            chk(fc_timeout == e_fc, cur_req, fc_timeout, e_fc);
            chk(to_timeout == e_to, cur_req, to_timeout, e_to);
            chk(chg_done == m_done, cur_req, chg_done, m_done);
        end
    end

    task automatic nxt(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic go_bulk();
        vb_below_pre_hys = 0; vb_at_term = 0; i_below_eoc = 0; i_below_topend = 0;
        vb_below_restart = 1; vb_above_pre = 1;
        nxt(2);
        chk(state == 2'd2, "R3", state, 2);
        vb_below_restart = 0;
    endtask

    task automatic count_pulse(input bit top, output int k);
        k = -1;
        for (int i = 1; i <= 2000; i++) begin
            nxt();
            if ((top ? to_timeout : fc_timeout) == 1'b1) begin
                k = i;
                break;
            end
        end
    endtask

    initial begin
        int k;
        cur_req = "R1";
        nxt(3);
        chk(state == 0 && lim_sel == 0 && !chg_done && !fc_timeout && !to_timeout, "R1", state, 0);
        rst = 0;
        nxt();
        chk(state == 0 && chg_done == 0, "R1", state, 0);

        cur_req = "R2";
        vb_below_restart = 1;
        nxt(3);
        chk(state == 0, "R2 enable low", state, 0);
        chg_en = 1; fault_flags = 4'b0100;
        nxt(3);
        chk(state == 0, "R2 fault present", state, 0);
        fault_flags = 0; vb_below_restart = 0;
        nxt(3);
        chk(state == 0, "R2 not below restart", state, 0);
        vb_below_restart = 1;
        nxt();
        chk(state == 1 && lim_sel == 1, "R2", state, 1);

        cur_req = "R3";
        vb_below_restart = 0; vb_above_pre = 1;
        nxt();
        chk(state == 2 && lim_sel == 2, "R3", state, 2);
        vb_above_pre = 0; vb_below_pre_hys = 1;
        nxt();
        chk(state == 1, "R3 fall back", state, 1);
        vb_below_pre_hys = 0; vb_above_pre = 1;
        nxt();
        chk(state == 2, "R3 rise again", state, 2);

        cur_req = "R4";
        to_code = 7; vb_at_term = 1; i_below_eoc = 1;
        nxt();
        chk(state == 3 && lim_sel == 3, "R4", state, 3);
        min_tick = 1;
        nxt(30);
        chk(state == 3 && !to_timeout, "R7 disabled code", state, 3);
        min_tick = 0;

        cur_req = "R5";
        i_below_topend = 1;
        nxt();
        chk(state == 0 && chg_done, "R5", chg_done, 1);
        i_below_topend = 0; vb_at_term = 0; i_below_eoc = 0;
        nxt(4);
        chk(chg_done == 1 && state == 0, "R5 hold", chg_done, 1);
        vb_below_restart = 1;
        nxt();
        chk(chg_done == 0 && state == 1, "R5 clear", chg_done, 0);
        vb_below_restart = 0;
        nxt();

        cur_req = "R6";
        fc_code = 1;
        min_tick = 0; vb_above_pre = 1;
        nxt();
        chk(state == 2, "R6 setup", state, 2);
        min_tick = 1;
        count_pulse(1'b0, k);
        chk(k == 200, "R6 200 min", k, 200);
        nxt();
        chk(state == 0, "R6 to idle", state, 0);
        min_tick = 0;
        fc_code = 0;
        go_bulk();
        min_tick = 1;
        nxt(1500);
        chk(state == 2 && !fc_timeout, "R6 disabled", state, 2);
        min_tick = 0;

        cur_req = "R8";
        chg_en = 0;
        nxt();
        chk(state == 0, "R8 enable low", state, 0);
        chg_en = 1;

        cur_req = "R9";
        fc_code = 1;
        go_bulk();
        min_tick = 1;
        nxt(150);
        fault_flags = 4'b0001;
        nxt();
        chk(state == 0, "R8 fault", state, 0);
        fault_flags = 0; min_tick = 0;
        go_bulk();
        min_tick = 1;
        count_pulse(1'b0, k);
        chk(k == 200, "R9 timer restarted", k, 200);
        min_tick = 0;
        nxt();

        cur_req = "R7";
        fc_code = 0; to_code = 0;
        go_bulk();
        vb_at_term = 1; i_below_eoc = 1;
        nxt();
        chk(state == 3 && to_timeout, "R7 code 0", to_timeout, 1);
        nxt();
        chk(state == 0, "R7 to idle", state, 0);
        to_code = 1;
        go_bulk();
        vb_at_term = 1; i_below_eoc = 1;
        nxt();
        chk(state == 3, "R7 setup", state, 3);
        min_tick = 1;
        count_pulse(1'b1, k);
        chk(k == 20, "R7 20 min", k, 20);
        min_tick = 0;
        nxt();

        cur_req = "R11";
        fc_code = 1; to_code = 7;
        go_bulk();
        min_tick = 1;
        nxt(199);
        min_tick = 0; vb_at_term = 1; i_below_eoc = 1;
        nxt();
        chk(state == 3 && !fc_timeout, "R11 setup", state, 3);
        min_tick = 1;
        nxt();
        min_tick = 0; i_below_topend = 1;
        #0;
        chk(fc_timeout == 1, "R11 fc wins", fc_timeout, 1);
        nxt();
        chk(state == 0 && chg_done == 0, "R11 no done", chg_done, 0);
        i_below_topend = 0; vb_at_term = 0; i_below_eoc = 0;
        nxt(2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule